// File: doc/BRIEF.md
# Multi-Window Inset Overlay Generator

This block decides, for every pixel of the main raster, whether an inset picture covers it and how that pixel is to be drawn. It takes the main pixel and line counters plus a set of static control fields. From these it places a vertical stack of up to four equal inset cells on the screen. Four cells of one quarter width and height are used in the small size, and three cells of one third width and height in the large size. For each pixel it reports the covering cell, whether the pixel lies on that cell's frame, and which override applies inside it: black, a solid fill colour, or normal video. It also raises a write strobe for the store of the one cell that currently takes live video.

The cell geometry is derived from the control fields and held in a register stage. The pixel decision comes from one comparator per cell, built by a generate loop, and a small priority stage. All per-pixel outputs are registered, so the decision for the counters presented in one cycle appears after the next clock edge. Each cell is a frame of `BORDER` pixels and lines drawn around its video area. Placement is clamped so that the stack never leaves the active area and so never reaches the sync intervals.

Top module: `pip_overlay`

## Requirements
- R1: Cell size follows `size9`. When it is 0, a cell is ACT_W/4 pixels wide and ACT_H/4 lines high. When it is 1, a cell is ACT_W/3 wide and ACT_H/3 high, using integer division.
- R2: The stack holds 4 cells when `size9`=0 and 3 when `size9`=1. Cell i starts at line ys + i*cell_height, and all cells share the same left pixel xs. When `size9`=1, bit 3 of `win_on` and `live_sel`=3 have no effect.
- R3: Placement is xs = `xpos`*(ACT_W/64) and ys = `ypos`*(ACT_H/64), before clamping.
- R4: xs is limited to at most ACT_W - cell_width. ys is limited to at most ACT_H - (k+1)*cell_height, where k is the highest index of a displayed cell, or 0 when no cell is displayed. A pixel with x >= ACT_W or y >= ACT_H is never active.
- R5: `pip_act`=1 only inside a cell whose `win_on` bit is 1 and whose index is below the cell count. `win_idx` then gives that index; otherwise `win_idx`=0.
- R6: Inside a displayed cell, the outermost BORDER columns and rows set `border`=1 and `border_code`=`border_col`. Everywhere else `border_code` is 0.
- R7: In the non-border area of a displayed cell whose `win_blank` bit is 1, `black`=1 and `fill_sel`=0. The blank bit acts independently of the on bit, so a cell blanked while off shows black as soon as it is turned on. The border has priority over blank.
- R8: In the non-border area of a displayed, unblanked cell, `fill_sel` equals `fill_code`, where 0 means video and 1 to 3 mean solid colours. Elsewhere `fill_sel` is 0.
- R9: `mem_we`=1 exactly in the non-border area of cell `live_sel` when `live_sel` is below the cell count and `freeze`=0. This holds whatever that cell's on bit is.
- R10: While `freeze`=1, `mem_we` stays 0.
- R11: All outputs are registered and reflect the counters of the previous cycle. Synchronous active-high `rst` clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_x | input | XW | Main-raster pixel counter |
| line_y | input | YW | Main-raster line counter |
| size9 | input | 1 | 0: quarter-size cells (4), 1: third-size cells (3) |
| xpos | input | 6 | Horizontal start step |
| ypos | input | 6 | Vertical start step |
| live_sel | input | 2 | Index of the cell taking live video |
| win_on | input | 4 | Per-cell display enable |
| win_blank | input | 4 | Per-cell force-to-black |
| border_col | input | 3 | Frame colour code |
| fill_code | input | 2 | 0 video, 1..3 solid fill colour |
| freeze | input | 1 | Stop updating the live cell |
| pip_act | output | 1 | Pixel is covered by a displayed cell |
| win_idx | output | 2 | Index of the covering cell |
| border | output | 1 | Pixel lies on a cell frame |
| border_code | output | 3 | Frame colour for this pixel |
| black | output | 1 | Force pixel to black |
| fill_sel | output | 2 | Solid fill selection for this pixel |
| mem_we | output | 1 | Store write enable for the live cell |

## Verification
A single cell is probed just inside and just outside all four edges in both sizes. This separates the quarter and third dimensions and the frame width from the video area. Full stacks of four and of three cells show where each cell starts and that a fourth cell drops out in the large size. Extreme positions, with different sets of displayed cells, show whether the clamp follows the highest displayed cell. Blank, fill, live select and freeze are combined on neighbouring cells, including undisplayed and blanked-while-off cells. These combinations separate the priority order from the write strobe's independence of the on bits.

// File: rtl/pip_pkg.sv
package pip_pkg;
  localparam int MAXWIN = 4;
  localparam int POS_W  = 6;
  localparam int STEPS  = 64;
  typedef logic [1:0] win_idx_t;
  typedef logic [1:0] fill_t;
  typedef logic [2:0] colour_t;
endpackage

// File: rtl/pip_geom.sv
module pip_geom #(
  parameter int ACT_W = 256,
  parameter int ACT_H = 240,
  parameter int XW    = 10,
  parameter int YW    = 9
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   size9,
  input  logic [3:0]             win_on,
  input  logic [pip_pkg::POS_W-1:0] xpos,
  input  logic [pip_pkg::POS_W-1:0] ypos,
  output logic [XW-1:0]          xs,
  output logic [YW-1:0]          ys,
  output logic [XW-1:0]          cw,
  output logic [YW-1:0]          ch,
  output logic [2:0]             nwin
);
  localparam int CW_S  = ACT_W / 4;
  localparam int CW_L  = ACT_W / 3;
  localparam int CH_S  = ACT_H / 4;
  localparam int CH_L  = ACT_H / 3;
  localparam int XSTEP = ACT_W / pip_pkg::STEPS;
  localparam int YSTEP = ACT_H / pip_pkg::STEPS;

  int n_c, cw_c, ch_c, top_c, xr, xm, yr, ym;

  always_comb begin
    n_c  = size9 ? 3 : 4;
    cw_c = size9 ? CW_L : CW_S;
    ch_c = size9 ? CH_L : CH_S;
    top_c = 0;
    for (int i = 0; i < pip_pkg::MAXWIN; i++)
      if (i < n_c && win_on[i]) top_c = i;
    xr = int'(xpos) * XSTEP;
    xm = ACT_W - cw_c;
    yr = int'(ypos) * YSTEP;
    ym = ACT_H - (top_c + 1) * ch_c;
    if (xr > xm) xr = xm;
    if (yr > ym) yr = ym;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xs   <= '0;
      ys   <= '0;
      cw   <= XW'(CW_S);
      ch   <= YW'(CH_S);
      nwin <= 3'd4;
    end else begin
      xs   <= XW'(xr);
      ys   <= YW'(yr);
      cw   <= XW'(cw_c);
      ch   <= YW'(ch_c);
      nwin <= 3'(n_c);
    end
  end
endmodule

// File: rtl/pip_hit.sv
module pip_hit #(
  parameter int ACT_W = 256,
  parameter int ACT_H = 240,
  parameter int XW    = 10,
  parameter int YW    = 9,
  parameter int B     = 2,
  parameter int IDX   = 0
) (
  input  logic [XW-1:0] pix_x,
  input  logic [YW-1:0] line_y,
  input  logic [XW-1:0] xs,
  input  logic [YW-1:0] ys,
  input  logic [XW-1:0] cw,
  input  logic [YW-1:0] ch,
  output logic          in_cell,
  output logic          in_body
);
  int x, y, x0, x1, y0, y1;

  always_comb begin
    x  = int'(pix_x);
    y  = int'(line_y);
    x0 = int'(xs);
    x1 = x0 + int'(cw);
    y0 = int'(ys) + IDX * int'(ch);
    y1 = y0 + int'(ch);
    in_cell = (x < ACT_W) && (y < ACT_H) &&
              (x >= x0) && (x < x1) && (y >= y0) && (y < y1);
    in_body = in_cell && (x >= x0 + B) && (x < x1 - B) &&
              (y >= y0 + B) && (y < y1 - B);
  end
endmodule

// File: rtl/pip_overlay.sv
module pip_overlay #(
  parameter int ACT_W  = 256,
  parameter int ACT_H  = 240,
  parameter int XW     = 10,
  parameter int YW     = 9,
  parameter int BORDER = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [XW-1:0] pix_x,
  input  logic [YW-1:0] line_y,
  input  logic        size9,
  input  logic [5:0]  xpos,
  input  logic [5:0]  ypos,
  input  logic [1:0]  live_sel,
  input  logic [3:0]  win_on,
  input  logic [3:0]  win_blank,
  input  logic [2:0]  border_col,
  input  logic [1:0]  fill_code,
  input  logic        freeze,
  output logic        pip_act,
  output logic [1:0]  win_idx,
  output logic        border,
  output logic [2:0]  border_code,
  output logic        black,
  output logic [1:0]  fill_sel,
  output logic        mem_we
);
  import pip_pkg::*;

  logic [XW-1:0] xs, cw;
  logic [YW-1:0] ys, ch;
  logic [2:0]    nwin;
  logic [MAXWIN-1:0] cell_v, body_v;

  pip_geom #(.ACT_W(ACT_W), .ACT_H(ACT_H), .XW(XW), .YW(YW)) u_geom (
    .clk(clk), .rst(rst), .size9(size9), .win_on(win_on),
    .xpos(xpos), .ypos(ypos),
    .xs(xs), .ys(ys), .cw(cw), .ch(ch), .nwin(nwin)
  );

  for (genvar g = 0; g < MAXWIN; g++) begin : g_win
    pip_hit #(.ACT_W(ACT_W), .ACT_H(ACT_H), .XW(XW), .YW(YW),
              .B(BORDER), .IDX(g)) u_hit (
      .pix_x(pix_x), .line_y(line_y), .xs(xs), .ys(ys), .cw(cw), .ch(ch),
      .in_cell(cell_v[g]), .in_body(body_v[g])
    );
  end

  logic     act_c, body_c, blank_c, we_c;
  win_idx_t idx_c;

  always_comb begin
    act_c   = 1'b0;
    body_c  = 1'b0;
    blank_c = 1'b0;
    idx_c   = '0;
    for (int i = 0; i < MAXWIN; i++) begin
      if (i < int'(nwin) && win_on[i] && cell_v[i]) begin
        act_c   = 1'b1;
        body_c  = body_v[i];
        blank_c = win_blank[i];
        idx_c   = win_idx_t'(i);
      end
    end
    we_c = (int'(live_sel) < int'(nwin)) && body_v[live_sel] && !freeze;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pip_act     <= 1'b0;
      win_idx     <= '0;
      border      <= 1'b0;
      border_code <= '0;
      black       <= 1'b0;
      fill_sel    <= '0;
      mem_we      <= 1'b0;
    end else begin
      pip_act     <= act_c;
      win_idx     <= idx_c;
      border      <= act_c && !body_c;
      border_code <= (act_c && !body_c) ? border_col : 3'd0;
      black       <= act_c && body_c && blank_c;
      fill_sel    <= (act_c && body_c && !blank_c) ? fill_code : 2'd0;
      mem_we      <= we_c;
    end
  end
endmodule

// File: rtl/pip_overlay_chk.sv
module pip_overlay_chk #(
  parameter int ACT_W = 256,
  parameter int XW    = 10
) (
  input logic          clk,
  input logic          rst,
  input logic [XW-1:0] pix_x,
  input logic          freeze,
  input logic          pip_act,
  input logic [1:0]    win_idx,
  input logic          border,
  input logic [2:0]    border_code,
  input logic          black,
  input logic [1:0]    fill_sel,
  input logic          mem_we
);
  AST_BORDER_IN_CELL: assert property (@(posedge clk) disable iff (rst) border |-> pip_act); // R6
  AST_CODE_OFF_BORDER: assert property (@(posedge clk) disable iff (rst) !border |-> border_code == 3'd0); // R6
  AST_BLACK_PRIO: assert property (@(posedge clk) disable iff (rst) black |-> (pip_act && !border && fill_sel == 2'd0)); // R7
  AST_FILL_PRIO: assert property (@(posedge clk) disable iff (rst) (fill_sel != 2'd0) |-> (pip_act && !border && !black)); // R8
  AST_FREEZE_NO_WRITE: assert property (@(posedge clk) disable iff (rst) freeze |=> !mem_we); // R10
  AST_OUTSIDE_IDLE: assert property (@(posedge clk) disable iff (rst) (int'(pix_x) >= ACT_W) |=> !pip_act); // R4
  AST_IDLE_INDEX: assert property (@(posedge clk) disable iff (rst) !pip_act |-> win_idx == 2'd0); // R5
endmodule

bind pip_overlay pip_overlay_chk #(.ACT_W(ACT_W), .XW(XW)) u_chk (
  .clk(clk), .rst(rst), .pix_x(pix_x), .freeze(freeze),
  .pip_act(pip_act), .win_idx(win_idx), .border(border),
  .border_code(border_code), .black(black), .fill_sel(fill_sel),
  .mem_we(mem_we)
);

// File: tb/sim_pip_overlay.sv
module sim_pip_overlay;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [9:0] pix_x = '0;
  logic [8:0] line_y = '0;
  logic size9 = 1'b0;
  logic [5:0] xpos = '0, ypos = '0;
  logic [1:0] live_sel = '0;
  logic [3:0] win_on = '0, win_blank = '0;
  logic [2:0] border_col = 3'd5;
  logic [1:0] fill_code = '0;
  logic freeze = 1'b0;
  logic pip_act, border, black, mem_we;
  logic [1:0] win_idx, fill_sel;
  logic [2:0] border_code;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pip_overlay u0 (
    .clk(clk), .rst(rst), .pix_x(pix_x), .line_y(line_y), .size9(size9),
    .xpos(xpos), .ypos(ypos), .live_sel(live_sel), .win_on(win_on),
    .win_blank(win_blank), .border_col(border_col), .fill_code(fill_code),
    .freeze(freeze), .pip_act(pip_act), .win_idx(win_idx), .border(border),
    .border_code(border_code), .black(black), .fill_sel(fill_sel),
    .mem_we(mem_we)
  );

  // packed result: act, idx[2], border, code[3], black, fill[2], we
  function automatic logic [10:0] pk(input logic a, input logic [1:0] i,
      input logic b, input logic [2:0] c, input logic k,
      input logic [1:0] f, input logic w);
    return {a, i, b, c, k, f, w};
  endfunction

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic cfg(input logic s9, input logic [5:0] xp, input logic [5:0] yp,
                     input logic [3:0] on, input logic [3:0] bl,
                     input logic [1:0] lv, input logic [1:0] fc, input logic fz);
    @(negedge clk);
    size9 = s9; xpos = xp; ypos = yp; win_on = on; win_blank = bl;
    live_sel = lv; fill_code = fc; freeze = fz;
    settle();
  endtask

  task automatic probe(input string tag, input int x, input int y,
                       input logic [10:0] exp);
    logic [10:0] got;
    @(negedge clk);
    pix_x = 10'(x); line_y = 9'(y);
    @(negedge clk);
    pix_x = 10'd300; line_y = 9'd250;
    got = pk(pip_act, win_idx, border, border_code, black, fill_sel, mem_we);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s at (%0d,%0d): actual=%b expected=%b", tag, x, y, got, exp);
    end
  endtask

  task automatic t_reset();
    pix_x = 10'd60; line_y = 9'd50; win_on = 4'b0001;
    repeat (3) @(negedge clk);
    checks++;
    if (pk(pip_act, win_idx, border, border_code, black, fill_sel, mem_we) !== 11'd0) begin
      fails++;
      $display("FAIL R11 reset: actual=%b expected=%b",
               pk(pip_act, win_idx, border, border_code, black, fill_sel, mem_we), 11'd0);
    end
    rst = 1'b0;
  endtask

  // single small cell: xs=40, ys=30, 64x60
  task automatic t_single_small();
    cfg(0, 6'd10, 6'd10, 4'b0001, 4'b0000, 2'd0, 2'd0, 0);
    probe("R3 R5 body", 60, 50, pk(1, 0, 0, 0, 0, 0, 1));
    probe("R6 left frame", 40, 50, pk(1, 0, 1, 5, 0, 0, 0));
    probe("R1 R6 right frame", 103, 50, pk(1, 0, 1, 5, 0, 0, 0));
    probe("R1 right outside", 104, 50, pk(0, 0, 0, 0, 0, 0, 0));
    probe("R3 left outside", 39, 50, pk(0, 0, 0, 0, 0, 0, 0));
    probe("R6 top frame", 60, 30, pk(1, 0, 1, 5, 0, 0, 0));
    probe("R3 above", 60, 29, pk(0, 0, 0, 0, 0, 0, 0));
    probe("R1 bottom frame", 60, 89, pk(1, 0, 1, 5, 0, 0, 0));
    probe("R5 next cell off", 60, 100, pk(0, 0, 0, 0, 0, 0, 0));
  endtask

  // single large cell: 85x80
  task automatic t_single_large();
    cfg(1, 6'd10, 6'd10, 4'b0001, 4'b0000, 2'd0, 2'd0, 0);
    probe("R1 large right frame", 124, 50, pk(1, 0, 1, 5, 0, 0, 0));
    probe("R1 large right outside", 125, 50, pk(0, 0, 0, 0, 0, 0, 0));
    probe("R1 large bottom frame", 60, 109, pk(1, 0, 1, 5, 0, 0, 0));
    probe("R1 large body", 110, 100, pk(1, 0, 0, 0, 0, 0, 1));
  endtask

  task automatic t_stack();
    cfg(0, 6'd10, 6'd10, 4'b1111, 4'b0000, 2'd2, 2'd0, 0);
    probe("R2 cell2 live", 60, 130, pk(1, 2, 0, 0, 0, 0, 1));
    probe("R2 cell3", 60, 200, pk(1, 3, 0, 0, 0, 0, 0));
    probe("R2 cell1 top frame", 60, 61, pk(1, 1, 1, 5, 0, 0, 0));
    cfg(1, 6'd10, 6'd10, 4'b1111, 4'b0000, 2'd2, 2'd0, 0);
    probe("R2 large cell2", 60, 200, pk(1, 2, 0, 0, 0, 0, 1));
    probe("R2 large cell1", 60, 100, pk(1, 1, 0, 0, 0, 0, 0));
    cfg(1, 6'd10, 6'd10, 4'b1000, 4'b0000, 2'd0, 2'd0, 0);
    probe("R2 fourth ignored", 60, 50, pk(0, 0, 0, 0, 0, 0, 1));
    probe("R2 fourth ignored low", 60, 230, pk(0, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_clamp();
    cfg(0, 6'd63, 6'd63, 4'b0001, 4'b0000, 2'd0, 2'd0, 0);
    probe("R4 clamped body", 200, 200, pk(1, 0, 0, 0, 0, 0, 1));
    probe("R4 corner frame", 255, 239, pk(1, 0, 1, 5, 0, 0, 0));
    probe("R4 beyond width", 256, 200, pk(0, 0, 0, 0, 0, 0, 0));
    cfg(0, 6'd63, 6'd63, 4'b0011, 4'b0000, 2'd0, 2'd0, 0);
    probe("R4 two-cell top", 200, 130, pk(1, 0, 0, 0, 0, 0, 1));
    probe("R4 two-cell bottom", 200, 190, pk(1, 1, 0, 0, 0, 0, 0));
    cfg(1, 6'd63, 6'd0, 4'b0001, 4'b0000, 2'd0, 2'd0, 0);
    probe("R4 large x clamp", 171, 40, pk(1, 0, 1, 5, 0, 0, 0));
    probe("R4 large x clamp out", 170, 40, pk(0, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_blank_fill();
    cfg(0, 6'd10, 6'd10, 4'b0011, 4'b0010, 2'd0, 2'd2, 0);
    probe("R7 blanked body", 60, 100, pk(1, 1, 0, 0, 1, 0, 0));
    probe("R7 frame over blank", 40, 100, pk(1, 1, 1, 5, 0, 0, 0));
    probe("R8 fill body", 60, 50, pk(1, 0, 0, 0, 0, 2, 1));
    probe("R8 no fill on frame", 40, 50, pk(1, 0, 1, 5, 0, 0, 0));
    cfg(0, 6'd10, 6'd10, 4'b0011, 4'b0100, 2'd0, 2'd0, 0);
    probe("R7 blanked while off", 60, 160, pk(0, 0, 0, 0, 0, 0, 0));
    cfg(0, 6'd10, 6'd10, 4'b0111, 4'b0100, 2'd0, 2'd0, 0);
    probe("R7 black once on", 60, 160, pk(1, 2, 0, 0, 1, 0, 0));
  endtask

  task automatic t_live_freeze();
    cfg(0, 6'd10, 6'd10, 4'b0001, 4'b0000, 2'd1, 2'd0, 0);
    probe("R9 write with cell off", 60, 100, pk(0, 0, 0, 0, 0, 0, 1));
    probe("R9 no write on frame", 40, 100, pk(0, 0, 0, 0, 0, 0, 0));
    probe("R9 other cell no write", 60, 50, pk(1, 0, 0, 0, 0, 0, 0));
    cfg(0, 6'd10, 6'd10, 4'b0001, 4'b0000, 2'd1, 2'd0, 1);
    probe("R10 frozen", 60, 100, pk(0, 0, 0, 0, 0, 0, 0));
    cfg(0, 6'd10, 6'd10, 4'b0001, 4'b0000, 2'd3, 2'd0, 0);
    probe("R9 live cell3 small", 60, 220, pk(0, 0, 0, 0, 0, 0, 1));
    cfg(1, 6'd10, 6'd10, 4'b0001, 4'b0000, 2'd3, 2'd0, 0);
    probe("R2 R9 live3 large", 60, 220, pk(0, 0, 0, 0, 0, 0, 0));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_single_small();
    t_single_large();
    t_stack();
    t_clamp();
    t_blank_fill();
    t_live_freeze();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule